// File: doc/BRIEF.md
# While-lower predicate generator

This block builds a per-byte predicate mask for a vector of fixed length from two unsigned scalar operands. From the lowest element upward it counts a copy of the first operand, one step per element. An element is true while that counted value is below the second operand, or at most equal to it in the inclusive mode. After the first element that fails, every higher element is false. The count always moves by one per element, whatever the element size. It is computed at the full selected scalar width and wraps modulo that width.

The scalar width (32 or 64 bits), the element size (1, 2, 4 or 8 bytes) and the compare mode are inputs. The vector length in bytes is a parameter. The predicate and four condition flags come from a single register stage, so results appear one clock after the operands are presented. The first operand is only read and is never altered.

Top module: `wlo_pred_gen`

## Requirements
- R1: While rst_n is low and after its release until the first capturing edge, pred_o is all zero, flag_n is 0, flag_z is 1, flag_c is 1 and flag_v is 0.
- R2: Each rising clock edge with rst_n high captures the inputs, and all outputs reflect those inputs until the next rising edge.
- R3: elem_size selects the element size: 2'b00 is 1 byte, 2'b01 is 2 bytes, 2'b10 is 4 bytes and 2'b11 is 8 bytes. There are VL_BYTES divided by that size elements. Element k drives pred_o bit k*size, and every other bit of its slot is 0.
- R4: wide_sel=1 uses all 64 operand bits. wide_sel=0 uses only bits 31:0 of both operands, so bits 63:32 have no effect on any output.
- R5: Element k compares (src_a + k) mod 2^W against src_b as unsigned values, where W is the selected width. incl_mode=0 tests for strictly less, and incl_mode=1 tests for less or equal.
- R6: An element is true only if its own comparison and the comparisons of all lower elements succeed. After one failure every higher element is false, even when a wrapped count would pass again.
- R7: flag_n equals the predicate bit of element 0.
- R8: flag_z is 1 exactly when no pred_o bit is set.
- R9: flag_c is 1 exactly when the predicate bit of the highest element is 0.
- R10: flag_v is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a | input | 64 | Starting value that is counted up per element |
| src_b | input | 64 | Bound compared against each counted value |
| wide_sel | input | 1 | 1: 64-bit operands, 0: 32-bit operands |
| elem_size | input | 2 | Element size select |
| incl_mode | input | 1 | 0: strictly less, 1: less or equal |
| pred_o | output | VL_BYTES | Predicate, one bit per vector byte |
| flag_n | output | 1 | First element active |
| flag_z | output | 1 | No element active |
| flag_c | output | 1 | Last element inactive |
| flag_v | output | 1 | Always zero |

## Verification
The hard case is the overlap of counter wraparound with the termination of the running chain. In one cycle a count that has wrapped can pass its comparison again, while an earlier failure must still hold that element false. It is provoked in 32-bit mode with a start value just below the maximum: a small bound makes element 0 fail while wrapped counts would pass, and a maximal bound in inclusive mode keeps the whole chain true across the wrap. Both results, and seeded random mixes of width, size and mode, are judged against a bench loop that recomputes each element from the requirements.

// File: rtl/wlo_pkg.sv
package wlo_pkg;

  typedef enum logic [1:0] {
    ESZ_1B = 2'b00,
    ESZ_2B = 2'b01,
    ESZ_4B = 2'b10,
    ESZ_8B = 2'b11
  } esz_e;

  // Comparison of one element: the start value advanced by k at the
  // selected width, tested against the bound.
  function automatic logic elem_pass(input logic [63:0] a,
                                     input logic [63:0] b,
                                     input int unsigned k,
                                     input logic        wide,
                                     input logic        incl);
    logic [63:0] s64;
    logic [31:0] s32;
    s64 = a + 64'(k);
    s32 = a[31:0] + 32'(k);
    if (wide) return incl ? (s64 <= b) : (s64 < b);
    else      return incl ? (s32 <= b[31:0]) : (s32 < b[31:0]);
  endfunction

  function automatic int unsigned esz_bytes(input logic [1:0] sel);
    return 32'd1 << sel;
  endfunction

endpackage

// File: rtl/wlo_cmp_row.sv
module wlo_cmp_row #(
  parameter int NUM = 32
) (
  input  logic [63:0]    a,
  input  logic [63:0]    b,
  input  logic           wide,
  input  logic           incl,
  output logic [NUM-1:0] pass
);
  for (genvar k = 0; k < NUM; k++) begin : g_elem
    assign pass[k] = wlo_pkg::elem_pass(a, b, k, wide, incl);
  end
endmodule

// File: rtl/wlo_run_chain.sv
module wlo_run_chain #(
  parameter int NUM = 32
) (
  input  logic [NUM-1:0] pass,
  output logic [NUM-1:0] run
);
  assign run[0] = pass[0];
  for (genvar k = 1; k < NUM; k++) begin : g_link
    assign run[k] = run[k-1] & pass[k];
  end
endmodule

// File: rtl/wlo_scatter.sv
module wlo_scatter #(
  parameter int VL_BYTES = 32
) (
  input  logic [VL_BYTES-1:0] run,
  input  logic [1:0]          size,
  output logic [VL_BYTES-1:0] pred
);
  logic [3:0][VL_BYTES-1:0] lane;

  for (genvar s = 0; s < 4; s++) begin : g_size
    localparam int ESZ = 1 << s;
    for (genvar bi = 0; bi < VL_BYTES; bi++) begin : g_byte
      if ((bi % ESZ) == 0) begin : g_lead
        assign lane[s][bi] = run[bi / ESZ];
      end else begin : g_fill
        assign lane[s][bi] = 1'b0;
      end
    end
  end

  assign pred = lane[size];
endmodule

// File: rtl/wlo_flags.sv
module wlo_flags #(
  parameter int VL_BYTES = 32
) (
  input  logic [VL_BYTES-1:0] pred,
  input  logic [1:0]          size,
  output logic                n,
  output logic                z,
  output logic                c,
  output logic                v
);
  localparam int IW = $clog2(VL_BYTES);
  logic [IW-1:0] last_idx;

  assign last_idx = IW'(VL_BYTES - int'(wlo_pkg::esz_bytes(size)));
  assign n = pred[0];
  assign z = ~|pred;
  assign c = ~pred[last_idx];
  assign v = 1'b0;
endmodule

// File: rtl/wlo_pred_gen.sv
module wlo_pred_gen #(
  parameter int VL_BYTES = 32   // power of two, at least 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [63:0]         src_a,
  input  logic [63:0]         src_b,
  input  logic                wide_sel,
  input  logic [1:0]          elem_size,
  input  logic                incl_mode,
  output logic [VL_BYTES-1:0] pred_o,
  output logic                flag_n,
  output logic                flag_z,
  output logic                flag_c,
  output logic                flag_v
);
  localparam int NUM = VL_BYTES;  // element count at the smallest size

  logic [NUM-1:0] pass_w;
  logic [NUM-1:0] run_w;
  logic [NUM-1:0] run_q;
  logic [1:0]     size_q;

  wlo_cmp_row #(.NUM(NUM)) u_cmp (
    .a(src_a), .b(src_b), .wide(wide_sel), .incl(incl_mode), .pass(pass_w)
  );

  wlo_run_chain #(.NUM(NUM)) u_chain (.pass(pass_w), .run(run_w));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      size_q <= wlo_pkg::ESZ_1B;
    end else begin
      run_q  <= run_w;
      size_q <= elem_size;
    end
  end

  wlo_scatter #(.VL_BYTES(VL_BYTES)) u_scatter (
    .run(run_q), .size(size_q), .pred(pred_o)
  );

  wlo_flags #(.VL_BYTES(VL_BYTES)) u_flags (
    .pred(pred_o), .size(size_q),
    .n(flag_n), .z(flag_z), .c(flag_c), .v(flag_v)
  );

  // Bits that are not the leading byte of an element slot.
  logic [VL_BYTES-1:0] non_lead;
  always_comb begin
    for (int bi = 0; bi < VL_BYTES; bi++)
      non_lead[bi] = ((bi & (int'(wlo_pkg::esz_bytes(size_q)) - 1)) != 0);
  end

  assert_slot_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_o & non_lead) == '0);

  assert_prefix_form_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q & (run_q + 1'b1)) == '0);

  assert_first_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_sel && !incl_mode && (src_a >= src_b)) |=> !flag_n);

  assert_first_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_sel && incl_mode && (src_a <= src_b)) |=> flag_n);

  assert_n_vs_z_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_n == !flag_z);

  assert_v_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_v && (flag_z == (pred_o == '0)));
endmodule

// File: tb/wlo_pred_gen_bench.sv
module wlo_pred_gen_bench;
  localparam int VL = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [63:0]   src_a = '0;
  logic [63:0]   src_b = '0;
  logic          wide_sel = 1'b0;
  logic [1:0]    elem_size = 2'b00;
  logic          incl_mode = 1'b0;
  logic [VL-1:0] pred_o;
  logic          flag_n, flag_z, flag_c, flag_v;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  wlo_pred_gen #(.VL_BYTES(VL)) u_wlo_pred_gen (
    .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
    .wide_sel(wide_sel), .elem_size(elem_size), .incl_mode(incl_mode),
    .pred_o(pred_o), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .flag_v(flag_v)
  );

  // Model: walk elements, keep a live flag, write leading byte bits.
  function automatic logic [VL-1:0] model_pred(logic [63:0] a, logic [63:0] b,
                                               logic w, logic [1:0] sz, logic inc);
    logic [VL-1:0] r = '0;
    logic live = 1'b1;
    int step = 1 << sz;
    logic [63:0] cur = w ? a : {32'h0, a[31:0]};
    logic [63:0] lim = w ? b : {32'h0, b[31:0]};
    for (int k = 0; k < VL / step; k++) begin
      logic ok = inc ? (cur <= lim) : (cur < lim);
      live = live & ok;
      r[k*step] = live;
      cur = cur + 64'd1;
      if (!w) cur = {32'h0, cur[31:0]};
    end
    return r;
  endfunction

  task automatic chk_bit(string tag, logic got, logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, got, exp);
    end
  endtask

  task automatic chk_all(string tag, logic [VL-1:0] ep, logic [1:0] sz);
    int step = 1 << sz;
    n_tests++;
    if (pred_o !== ep) begin
      n_fail++;
      $display("FAIL %s pred actual=%h expected=%h", tag, pred_o, ep);
    end
    chk_bit("R7 flag_n", flag_n, ep[0]);
    chk_bit("R8 flag_z", flag_z, ep == '0);
    chk_bit("R9 flag_c", flag_c, !ep[VL-step]);
    chk_bit("R10 flag_v", flag_v, 1'b0);
  endtask

  task automatic run_case(string tag, logic [63:0] a, logic [63:0] b,
                          logic w, logic [1:0] sz, logic inc);
    @(negedge clk);
    src_a = a; src_b = b; wide_sel = w; elem_size = sz; incl_mode = inc;
    @(posedge clk);
    @(negedge clk);
    chk_all(tag, model_pred(a, b, w, sz, inc), sz);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    src_a = 64'd3; src_b = 64'd100; wide_sel = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state held while rst_n low
    chk_all("R1 reset", '0, 2'b00);
    rst_n = 1'b1;
    #1;
    chk_all("R1 after release", '0, 2'b00);

    // R3 element sizes, R5 strict compare
    for (int s = 0; s < 4; s++)
      run_case("R3 size sweep", 64'd10, 64'd14, 1'b1, 2'(s), 1'b0);
    // R5 equal operands, strict and inclusive
    run_case("R5 equal strict", 64'd77, 64'd77, 1'b1, 2'b00, 1'b0);
    run_case("R5 equal incl", 64'd77, 64'd77, 1'b1, 2'b00, 1'b1);
    // zero bound
    run_case("R5 zero bound", 64'd0, 64'd0, 1'b1, 2'b01, 1'b0);
    run_case("R5 zero bound incl", 64'd0, 64'd0, 1'b0, 2'b10, 1'b1);
    // full predicate for every size
    for (int s = 0; s < 4; s++)
      run_case("R3 all true", 64'd0, 64'd1000, 1'b0, 2'(s), 1'b0);
    // R4 upper bits ignored in narrow mode
    run_case("R4 narrow upper ignored", 64'hFFFF_0000_0000_0005,
             64'h0000_0000_0000_0009, 1'b0, 2'b00, 1'b0);
    run_case("R4 wide upper used", 64'hFFFF_0000_0000_0005,
             64'h0000_0000_0000_0009, 1'b1, 2'b00, 1'b0);
    // R6 wrap: failure persists although wrapped count passes
    run_case("R6 wrap kept false", 64'hFFFF_FFFE, 64'd5, 1'b0, 2'b00, 1'b0);
    run_case("R6 wrap mid chain", 64'hFFFF_FFFE, 64'hFFFF_FFFF, 1'b0, 2'b00, 1'b0);
    run_case("R6 wrap incl all true", 64'hFFFF_FFFE, 64'hFFFF_FFFF, 1'b0, 2'b00, 1'b1);
    run_case("R6 wrap 64", 64'hFFFF_FFFF_FFFF_FFFD, 64'hFFFF_FFFF_FFFF_FFFF,
             1'b1, 2'b00, 1'b1);

    // R2: outputs hold until the next capturing edge
    run_case("R2 setup", 64'd0, 64'd3, 1'b1, 2'b00, 1'b0);
    src_a = 64'd100; src_b = 64'd0;
    #3;
    chk_all("R2 hold before edge", model_pred(64'd0, 64'd3, 1'b1, 2'b00, 1'b0), 2'b00);

    // Seeded random mixes
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      logic [1:0] sz = 2'($urandom_range(0, 3));
      logic w = 1'($urandom_range(0, 1));
      logic inc = 1'($urandom_range(0, 1));
      a = {$urandom, $urandom};
      b = a + 64'($urandom_range(0, 40)) - 64'd4;
      if ((i % 5) == 0) b = {$urandom, $urandom};
      run_case("R5 random", a, b, w, sz, inc);
    end

    // R1: reset again clears outputs
    @(negedge clk);
    src_a = 64'd0; src_b = 64'd50; rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk_all("R1 re-reset", '0, 2'b00);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule